// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block holds the mode and interrupt-disable state of a small processor core and carries out the control side of taking and leaving an exception. It has no datapath of its own. Each cycle it looks at a fast interrupt request, a normal interrupt request, an exception-return strobe and a software write to the low byte of the status register. It then takes at most one of them. Taking an interrupt saves a return address and a full copy of the status register into the banks of the target mode. It then switches the mode field, sets the disable bits and sends the fetch unit to a fixed vector.

A return copies the active mode's saved status back into the shared status register. It then redirects fetch to the banked return address less a fixed offset. The fetch unit uses `redirect` as a one-cycle strobe that tells it to load `next_pc`. Banked link and saved-status values for the fast-interrupt, normal-interrupt and supervisor modes are brought out as ports.

Top module: `exc_seq_top`

## Requirements
- R1: After reset the status register reads 0xD3: mode field [4:0] = 0x13 (supervisor), bit 7 (normal-interrupt disable) = 1 and bit 6 (fast-interrupt disable) = 1. Also, `next_pc` = 0, `redirect` = 0, and every banked register reads 0.
- R2: A fast request taken at a clock edge gives the following after that edge: `lr_fiq` = `cur_pc` + 4, `spsr_fiq` = the status register as it was before the edge, mode field = 0x11, bits 7 and 6 both set, `next_pc` = 0x1C and `redirect` = 1.
- R3: A normal request taken at a clock edge gives the following after that edge: `lr_irq` = `cur_pc` + 4, `spsr_irq` = the prior status register, mode field = 0x12, bit 7 set and bit 6 unchanged, `next_pc` = 0x18 and `redirect` = 1.
- R4: A request whose disable bit is set (bit 7 for normal, bit 6 for fast) is ignored. `redirect` stays 0, and the status register and every banked register keep their values.
- R5: When both requests are accepted in the same cycle, the fast one is taken. `lr_irq` and `spsr_irq` are left unchanged.
- R6: A return strobe while the mode field is 0x11, 0x12 or 0x13 loads the status register from that mode's saved-status register. It also loads `next_pc` with that mode's link value minus 4 and raises `redirect`.
- R7: A return strobe while the mode field holds any other code (for example 0x10) is ignored. `redirect` stays 0 and the status register is unchanged.
- R8: A control write replaces bits [7:0] of the status register with the written byte and leaves the upper bits alone. Writing 0xD2 gives normal-interrupt mode with both classes disabled. Writing 0x53 gives supervisor mode with normal interrupts enabled and fast interrupts disabled.
- R9: Only one event is taken per cycle, in the order fast entry, normal entry, return, control write. Lower-ranked events arriving in the same cycle are dropped.
- R10: `redirect` is 1 only in the cycle after a taken entry or return. It is 0 after an idle cycle or after a control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Normal interrupt request |
| fiq_req | input | 1 | Fast interrupt request |
| eret_req | input | 1 | Exception-return strobe |
| cur_pc | input | ADDR_W | Program counter of the interrupted instruction stream |
| ctl_wr_en | input | 1 | Software write strobe for the status control byte |
| ctl_wr_data | input | 8 | Byte written to status bits [7:0] |
| next_pc | output | ADDR_W | Redirect target for fetch |
| redirect | output | 1 | One-cycle strobe: fetch loads `next_pc` |
| cpsr | output | PSR_W | Shared current status register |
| lr_fiq | output | ADDR_W | Banked link value, fast-interrupt mode |
| lr_irq | output | ADDR_W | Banked link value, normal-interrupt mode |
| lr_svc | output | ADDR_W | Banked link value, supervisor mode |
| spsr_fiq | output | PSR_W | Saved status, fast-interrupt mode |
| spsr_irq | output | PSR_W | Saved status, normal-interrupt mode |
| spsr_svc | output | PSR_W | Saved status, supervisor mode |

## Verification
The bench targets these corner cases:
- Simultaneous fast and normal requests. A design with the wrong priority would redirect to 0x18 and overwrite the normal-interrupt bank.
- Requests raised while their disable bit is set. A design that ignored the gate would save a new link value over the live one.
- Nested entry from normal-interrupt mode into fast mode, followed by two returns. A design that picked the wrong bank would come back to the wrong address or restore the wrong status.
- A return from a mode with no bank, and a return or write that collides with an entry. A design that let either through would corrupt the status register.

// File: rtl/exc_pkg.sv
package exc_pkg;

   localparam logic [4:0] MODE_USR = 5'h10;
   localparam logic [4:0] MODE_FIQ = 5'h11;
   localparam logic [4:0] MODE_IRQ = 5'h12;
   localparam logic [4:0] MODE_SVC = 5'h13;

   localparam int BIT_IDIS = 7;
   localparam int BIT_FDIS = 6;
   localparam int MODE_W   = 5;

   localparam int NUM_BANKS = 3;

   typedef enum logic [2:0] {
      EV_NONE,
      EV_FIQ,
      EV_IRQ,
      EV_RET,
      EV_WR
   } exc_ev_e;

   // Mode code owned by each bank slot: 0 fast, 1 normal, 2 supervisor
   function automatic logic [4:0] bank_mode(input int idx);
      case (idx)
         0:       return MODE_FIQ;
         1:       return MODE_IRQ;
         default: return MODE_SVC;
      endcase
   endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
   import exc_pkg::*;
#(
   parameter bit FIQ_FIRST = 1'b1
) (
   input  logic    fiq_req,
   input  logic    irq_req,
   input  logic    ret_req,
   input  logic    wr_req,
   input  logic    fiq_dis,
   input  logic    irq_dis,
   input  logic    ret_ok,
   output exc_ev_e ev
);

   logic fiq_go;
   logic irq_go;
   logic ret_go;

   assign fiq_go = fiq_req & ~fiq_dis;
   assign irq_go = irq_req & ~irq_dis;
   assign ret_go = ret_req & ret_ok;

   generate
      if (FIQ_FIRST) begin : g_fast_first
         always_comb begin
            if (fiq_go)      ev = EV_FIQ;
            else if (irq_go) ev = EV_IRQ;
            else if (ret_go) ev = EV_RET;
            else if (wr_req) ev = EV_WR;
            else             ev = EV_NONE;
         end
      end else begin : g_norm_first
         always_comb begin
            if (irq_go)      ev = EV_IRQ;
            else if (fiq_go) ev = EV_FIQ;
            else if (ret_go) ev = EV_RET;
            else if (wr_req) ev = EV_WR;
            else             ev = EV_NONE;
         end
      end
   endgenerate

endmodule

// File: rtl/exc_bank.sv
module exc_bank #(
   parameter int ADDR_W = 32,
   parameter int PSR_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              save_en,
   input  logic [ADDR_W-1:0] link_in,
   input  logic [PSR_W-1:0]  psr_in,
   output logic [ADDR_W-1:0] link_q,
   output logic [PSR_W-1:0]  psr_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         link_q <= '0;
         psr_q  <= '0;
      end else if (save_en) begin
         link_q <= link_in;
         psr_q  <= psr_in;
      end
   end

   // R4: a bank that is not being saved keeps its contents
   a_r4_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !save_en |=> ($stable(link_q) && $stable(psr_q)));

endmodule

// File: rtl/exc_psr.sv
module exc_psr
   import exc_pkg::*;
#(
   parameter int              PSR_W   = 32,
   parameter logic [PSR_W-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  exc_ev_e          ev,
   input  logic [PSR_W-1:0] restore_val,
   input  logic [7:0]       wr_byte,
   output logic [PSR_W-1:0] psr_q
);

   logic [PSR_W-1:0] psr_d;

   always_comb begin
      psr_d = psr_q;
      case (ev)
         EV_FIQ: begin
            psr_d[MODE_W-1:0] = MODE_FIQ;
            psr_d[BIT_IDIS]   = 1'b1;
            psr_d[BIT_FDIS]   = 1'b1;
         end
         EV_IRQ: begin
            psr_d[MODE_W-1:0] = MODE_IRQ;
            psr_d[BIT_IDIS]   = 1'b1;
         end
         EV_RET:  psr_d = restore_val;
         EV_WR:   psr_d[7:0] = wr_byte;
         default: psr_d = psr_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) psr_q <= RST_VAL;
      else        psr_q <= psr_d;
   end

   // R8: a control write never disturbs bits above the control byte
   generate
      if (PSR_W > 8) begin : g_upper_chk
         a_r8_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (ev == EV_WR) |=> (psr_q[PSR_W-1:8] == $past(psr_q[PSR_W-1:8])));
      end
   endgenerate

endmodule

// File: rtl/exc_seq_top.sv
module exc_seq_top
   import exc_pkg::*;
#(
   parameter int                ADDR_W    = 32,
   parameter int                PSR_W     = 32,
   parameter int                LINK_OFS  = 4,
   parameter int                RET_OFS   = 4,
   parameter logic [ADDR_W-1:0] VEC_RST   = 'h0,
   parameter logic [ADDR_W-1:0] VEC_IRQ   = 'h18,
   parameter logic [ADDR_W-1:0] VEC_FIQ   = 'h1C,
   parameter bit                FIQ_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_req,
   input  logic              fiq_req,
   input  logic              eret_req,
   input  logic [ADDR_W-1:0] cur_pc,
   input  logic              ctl_wr_en,
   input  logic [7:0]        ctl_wr_data,
   output logic [ADDR_W-1:0] next_pc,
   output logic              redirect,
   output logic [PSR_W-1:0]  cpsr,
   output logic [ADDR_W-1:0] lr_fiq,
   output logic [ADDR_W-1:0] lr_irq,
   output logic [ADDR_W-1:0] lr_svc,
   output logic [PSR_W-1:0]  spsr_fiq,
   output logic [PSR_W-1:0]  spsr_irq,
   output logic [PSR_W-1:0]  spsr_svc
);

   localparam logic [PSR_W-1:0] PSR_RST =
      PSR_W'({1'b1, 1'b1, 1'b0, MODE_SVC});
   localparam logic [ADDR_W-1:0] LINK_ADD = ADDR_W'(LINK_OFS);
   localparam logic [ADDR_W-1:0] RET_SUB  = ADDR_W'(RET_OFS);

   generate
      if (PSR_W < 8) begin : g_bad_psr
         $error("exc_seq_top: PSR_W must hold the control byte");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("exc_seq_top: ADDR_W too small for the vectors");
      end
   endgenerate

   exc_ev_e          ev;
   logic [4:0]       cur_mode;
   logic [4:0]       tgt_mode;
   logic             ret_ok;
   logic [ADDR_W-1:0] sel_link;
   logic [PSR_W-1:0]  sel_psr;
   logic [ADDR_W-1:0] bank_link [NUM_BANKS];
   logic [PSR_W-1:0]  bank_psr  [NUM_BANKS];
   logic [ADDR_W-1:0] ret_link;

   assign cur_mode = cpsr[MODE_W-1:0];
   assign tgt_mode = (ev == EV_FIQ) ? MODE_FIQ : MODE_IRQ;
   assign ret_link = cur_pc + LINK_ADD;

   // Bank lookup for the active mode
   always_comb begin
      ret_ok   = 1'b0;
      sel_link = '0;
      sel_psr  = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (cur_mode == bank_mode(b)) begin
            ret_ok   = 1'b1;
            sel_link = bank_link[b];
            sel_psr  = bank_psr[b];
         end
      end
   end

   exc_arbiter #(
      .FIQ_FIRST (FIQ_FIRST)
   ) u_arb (
      .fiq_req (fiq_req),
      .irq_req (irq_req),
      .ret_req (eret_req),
      .wr_req  (ctl_wr_en),
      .fiq_dis (cpsr[BIT_FDIS]),
      .irq_dis (cpsr[BIT_IDIS]),
      .ret_ok  (ret_ok),
      .ev      (ev)
   );

   generate
      for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
         logic save_here;
         assign save_here = ((ev == EV_FIQ) || (ev == EV_IRQ)) &&
                            (tgt_mode == bank_mode(g));
         exc_bank #(
            .ADDR_W (ADDR_W),
            .PSR_W  (PSR_W)
         ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .save_en (save_here),
            .link_in (ret_link),
            .psr_in  (cpsr),
            .link_q  (bank_link[g]),
            .psr_q   (bank_psr[g])
         );
      end
   endgenerate

   exc_psr #(
      .PSR_W   (PSR_W),
      .RST_VAL (PSR_RST)
   ) u_psr (
      .clk         (clk),
      .rst_n       (rst_n),
      .ev          (ev),
      .restore_val (sel_psr),
      .wr_byte     (ctl_wr_data),
      .psr_q       (cpsr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         next_pc  <= VEC_RST;
         redirect <= 1'b0;
      end else begin
         redirect <= 1'b0;
         case (ev)
            EV_FIQ: begin
               next_pc  <= VEC_FIQ;
               redirect <= 1'b1;
            end
            EV_IRQ: begin
               next_pc  <= VEC_IRQ;
               redirect <= 1'b1;
            end
            EV_RET: begin
               next_pc  <= sel_link - RET_SUB;
               redirect <= 1'b1;
            end
            default: next_pc <= next_pc;
         endcase
      end
   end

   assign lr_fiq   = bank_link[0];
   assign lr_irq   = bank_link[1];
   assign lr_svc   = bank_link[2];
   assign spsr_fiq = bank_psr[0];
   assign spsr_irq = bank_psr[1];
   assign spsr_svc = bank_psr[2];

   // ---------------- assertions ----------------
   logic fiq_take;
   logic irq_take;
   assign fiq_take = fiq_req && !cpsr[BIT_FDIS];
   assign irq_take = irq_req && !cpsr[BIT_IDIS];

   a_r2_fiq_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (FIQ_FIRST && fiq_take) |=>
         (cpsr[4:0] == MODE_FIQ && cpsr[BIT_IDIS] && cpsr[BIT_FDIS] &&
          next_pc == VEC_FIQ && redirect &&
          lr_fiq == $past(cur_pc) + LINK_ADD && spsr_fiq == $past(cpsr)));

   a_r3_irq_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (FIQ_FIRST && irq_take && !fiq_take) |=>
         (cpsr[4:0] == MODE_IRQ && cpsr[BIT_IDIS] &&
          cpsr[BIT_FDIS] == $past(cpsr[BIT_FDIS]) &&
          next_pc == VEC_IRQ && redirect &&
          lr_irq == $past(cur_pc) + LINK_ADD && spsr_irq == $past(cpsr)));

   a_r5_fast_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (FIQ_FIRST && fiq_take && irq_take) |=>
         ($stable(lr_irq) && $stable(spsr_irq)));

   a_r6_irq_return: assert property (@(posedge clk) disable iff (!rst_n)
      (eret_req && !fiq_take && !irq_take && cur_mode == MODE_IRQ) |=>
         (cpsr == $past(spsr_irq) && next_pc == $past(lr_irq) - RET_SUB && redirect));

   a_r7_bad_return: assert property (@(posedge clk) disable iff (!rst_n)
      (eret_req && !fiq_take && !irq_take && !ctl_wr_en &&
       cur_mode != MODE_FIQ && cur_mode != MODE_IRQ && cur_mode != MODE_SVC) |=>
         (!redirect && $stable(cpsr)));

   a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      (!fiq_take && !irq_take && !eret_req) |=> !redirect);

endmodule

// File: tb/exc_seq_top_bench.sv
module exc_seq_top_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        irq_req, fiq_req, eret_req, ctl_wr_en;
   logic [31:0] cur_pc;
   logic [7:0]  ctl_wr_data;
   logic [31:0] next_pc, cpsr, lr_fiq, lr_irq, lr_svc;
   logic [31:0] spsr_fiq, spsr_irq, spsr_svc;
   logic        redirect;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   exc_seq_top u_exc_seq_top (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .fiq_req(fiq_req),
      .eret_req(eret_req), .cur_pc(cur_pc), .ctl_wr_en(ctl_wr_en),
      .ctl_wr_data(ctl_wr_data), .next_pc(next_pc), .redirect(redirect),
      .cpsr(cpsr), .lr_fiq(lr_fiq), .lr_irq(lr_irq), .lr_svc(lr_svc),
      .spsr_fiq(spsr_fiq), .spsr_irq(spsr_irq), .spsr_svc(spsr_svc)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic idle_inputs();
      irq_req = 0; fiq_req = 0; eret_req = 0; ctl_wr_en = 0; ctl_wr_data = 8'h00;
   endtask

   task automatic do_write(input logic [7:0] b);
      ctl_wr_en = 1; ctl_wr_data = b;
      cyc();
      idle_inputs();
   endtask

   task automatic t_reset();
      chk("R1 cpsr", cpsr, 32'hD3);
      chk("R1 next_pc", next_pc, 32'h0);
      chk("R1 redirect", {31'b0, redirect}, 32'h0);
      chk("R1 lr_irq", lr_irq, 32'h0);
      chk("R1 spsr_fiq", spsr_fiq, 32'h0);
      chk("R1 lr_svc", lr_svc, 32'h0);
   endtask

   task automatic t_write();
      do_write(8'hD2);
      chk("R8 write D2", cpsr, 32'hD2);
      chk("R10 no redirect on write", {31'b0, redirect}, 32'h0);
      do_write(8'h53);
      chk("R8 write 53", cpsr, 32'h53);
   endtask

   task automatic t_fiq_masked();
      fiq_req = 1; cur_pc = 32'h0000_0080;
      cyc();
      idle_inputs();
      chk("R4 fiq masked redirect", {31'b0, redirect}, 32'h0);
      chk("R4 fiq masked cpsr", cpsr, 32'h53);
      chk("R4 fiq masked lr", lr_fiq, 32'h0);
   endtask

   task automatic t_irq_entry();
      irq_req = 1; cur_pc = 32'h0000_0100;
      cyc();
      idle_inputs();
      chk("R3 lr_irq", lr_irq, 32'h104);
      chk("R3 spsr_irq", spsr_irq, 32'h53);
      chk("R3 cpsr", cpsr, 32'hD2);
      chk("R3 next_pc", next_pc, 32'h18);
      chk("R3 redirect", {31'b0, redirect}, 32'h1);
      cyc();
      chk("R10 redirect drops", {31'b0, redirect}, 32'h0);
   endtask

   task automatic t_irq_masked();
      irq_req = 1; cur_pc = 32'h0000_0200;
      cyc();
      idle_inputs();
      chk("R4 irq masked redirect", {31'b0, redirect}, 32'h0);
      chk("R4 irq masked lr", lr_irq, 32'h104);
      chk("R4 irq masked cpsr", cpsr, 32'hD2);
   endtask

   task automatic t_irq_return();
      eret_req = 1;
      cyc();
      idle_inputs();
      chk("R6 irq ret cpsr", cpsr, 32'h53);
      chk("R6 irq ret pc", next_pc, 32'h100);
      chk("R6 irq ret redirect", {31'b0, redirect}, 32'h1);
   endtask

   task automatic t_both();
      do_write(8'h13);
      fiq_req = 1; irq_req = 1; cur_pc = 32'h0000_0300;
      cyc();
      idle_inputs();
      chk("R5 fast taken pc", next_pc, 32'h1C);
      chk("R5 lr_irq kept", lr_irq, 32'h104);
      chk("R5 spsr_irq kept", spsr_irq, 32'h53);
      chk("R2 lr_fiq", lr_fiq, 32'h304);
      chk("R2 spsr_fiq", spsr_fiq, 32'h13);
      chk("R2 cpsr", cpsr, 32'hD1);
      eret_req = 1;
      cyc();
      idle_inputs();
      chk("R6 fiq ret cpsr", cpsr, 32'h13);
      chk("R6 fiq ret pc", next_pc, 32'h300);
   endtask

   task automatic t_collide();
      irq_req = 1; eret_req = 1; ctl_wr_en = 1; ctl_wr_data = 8'hFF;
      cur_pc = 32'h0000_0400;
      cyc();
      idle_inputs();
      chk("R9 entry over ret/write cpsr", cpsr, 32'h92);
      chk("R9 entry pc", next_pc, 32'h18);
      chk("R9 lr_irq", lr_irq, 32'h404);
      eret_req = 1; ctl_wr_en = 1; ctl_wr_data = 8'hFF;
      cyc();
      idle_inputs();
      chk("R9 ret over write cpsr", cpsr, 32'h13);
      chk("R9 ret pc", next_pc, 32'h400);
   endtask

   task automatic t_bad_return();
      do_write(8'h10);
      chk("R8 write 10", cpsr, 32'h10);
      eret_req = 1;
      cyc();
      idle_inputs();
      chk("R7 user ret redirect", {31'b0, redirect}, 32'h0);
      chk("R7 user ret cpsr", cpsr, 32'h10);
   endtask

   task automatic t_nested();
      irq_req = 1; cur_pc = 32'h0000_0600;
      cyc();
      idle_inputs();
      chk("R3 user entry spsr", spsr_irq, 32'h10);
      chk("R3 user entry cpsr", cpsr, 32'h92);
      fiq_req = 1; cur_pc = 32'h0000_0500;
      cyc();
      idle_inputs();
      chk("R2 nested lr_fiq", lr_fiq, 32'h504);
      chk("R2 nested spsr_fiq", spsr_fiq, 32'h92);
      chk("R2 nested cpsr", cpsr, 32'hD1);
      eret_req = 1;
      cyc();
      chk("R6 nested back cpsr", cpsr, 32'h92);
      chk("R6 nested back pc", next_pc, 32'h500);
      cyc();
      idle_inputs();
      chk("R6 outer back cpsr", cpsr, 32'h10);
      chk("R6 outer back pc", next_pc, 32'h600);
   endtask

   task automatic t_svc_return();
      do_write(8'h13);
      eret_req = 1;
      cyc();
      idle_inputs();
      chk("R6 svc ret cpsr", cpsr, 32'h0);
      chk("R6 svc ret pc", next_pc, 32'hFFFF_FFFC);
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      idle_inputs();
      cur_pc = 32'h0;
      rst_n = 0;
      repeat (3) cyc();
      rst_n = 1;
      t_reset();
      t_write();
      t_fiq_masked();
      t_irq_entry();
      t_irq_masked();
      t_irq_return();
      t_both();
      t_collide();
      t_bad_return();
      t_nested();
      t_svc_return();
      cyc();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule